// File: doc/BRIEF.md
# Buffered UART Transmitter with RS485 Driver Enable

This block serialises bytes onto an asynchronous serial line. A one-byte holding stage sits in front of the frame shifter. A byte offered on the input stream is latched into the holding stage. It moves into the shifter on the next clock whenever the shifter is idle or is finishing its last bit, so consecutive frames follow each other with no idle gap. The ready output is high whenever the holding stage can take a byte. Because of this, an external DMA engine can use it directly as its transfer request.

With two stages of buffering, the feeder's last byte is accepted while close to two frames are still to be shifted out. For this reason the block keeps a separate line-complete flag, which sets only once the final stop bit has left the line and nothing is waiting. That flag can raise an interrupt, and software clears it with a one-cycle clear pulse. The RS485 driver-enable output rises with the first accepted byte of a message. It falls on the line-complete event only, never when the holding stage empties.

Input stream rules: a byte transfers on a clock edge where `in_valid` and `in_ready` are both high. While `in_ready` is low the source must hold `in_valid` and `in_data` steady, and nothing in the block changes because of them. The frame format is sampled when a byte enters the shifter: the bit divisor, parity enable, parity sense and stop-bit count.

Top module: `uart_tx_rs485`

## Requirements
- R1: After reset `txd` is 1, `in_ready` is 1, and `tc_flag`, `tc_irq` and `de` are 0. `txd` stays 1 whenever no frame is being shifted.
- R2: A frame starts with one low start bit, followed by the 8 data bits LSB first. Every bit lasts exactly `cfg_div` clock cycles (`cfg_div` ≥ 1).
- R3: With `cfg_par_en`=1 a parity bit follows bit 7 of the data. With `cfg_par_odd`=0 it makes the count of ones over data plus parity even; with `cfg_par_odd`=1 it makes that count odd. With `cfg_par_en`=0 no parity bit is sent.
- R4: The frame ends with one high stop bit when `cfg_two_stop`=0, and with two high stop bits when `cfg_two_stop`=1.
- R5: A byte accepted at edge k enters an idle shifter at edge k+1, and `in_ready` is high again after that edge. A byte that is waiting enters the shifter on the same edge that ends the previous frame's last stop bit, so there is no idle gap.
- R6: While the holding stage is full, `in_ready` is 0 and a held `in_valid` has no effect on any output.
- R7: `tc_flag` sets on the edge that ends a last stop bit, provided the holding stage is empty and `in_valid` is low. It does not set between the frames of a continuous message.
- R8: `tc_flag` clears on a `tc_clr` pulse or when a byte is accepted. `tc_irq` is high exactly when `tc_flag` and `tc_ie` are both high.
- R9: `de` rises on the edge that accepts a byte and falls only on the edge where `tc_flag` sets. For a message of N bytes fed without pause, first accepted at edge a, `de` falls at edge a + 1 + N·B·cfg_div, where B is the number of bits per frame. This is checked for N = 1, 2, 5 and 10.
- R10: Divisor, parity and stop settings are captured when a byte enters the shifter. Changing them in the middle of a frame does not alter that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | DIV_W | Clock cycles per bit (clock / baud) |
| cfg_par_en | input | 1 | Insert a parity bit |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits |
| tc_ie | input | 1 | Line-complete interrupt enable |
| tc_clr | input | 1 | One-cycle pulse clearing the line-complete flag |
| in_valid | input | 1 | Stream byte valid |
| in_ready | output | 1 | Holding stage empty; doubles as DMA request |
| in_data | input | DATA_W | Stream byte |
| txd | output | 1 | Serial line, idles high |
| tc_flag | output | 1 | Line-complete flag |
| tc_irq | output | 1 | Line-complete interrupt |
| de | output | 1 | RS485 driver enable |

## Verification
Messages of 1, 2, 5 and 10 bytes are pushed through with the source always valid. Under that load the holding stage fills and stalls, which separates the early ready/request behaviour from the late line-complete event and shows exactly where the driver enable falls. Even parity, odd parity, two stop bits and a divisor of one are each exercised with distinct data patterns (counting bytes, all-ones/all-zeros, alternating bits), so that a wrong parity sense, a dropped stop bit or an off-by-one bit length shows up on the line. Further tests clear the flag with the interrupt enabled and change the configuration in the middle of a frame, which separates the flag-clear paths and confirms the frame-time capture of the settings.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef struct packed {
    logic par_en;
    logic par_odd;
    logic two_stop;
  } frame_cfg_t;
endpackage

// File: rtl/tx_hold_stage.sv
module tx_hold_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data_q
);
  logic accept;
  assign accept = in_valid && !full;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      data_q <= '0;
    end else if (accept) begin
      full   <= 1'b1;
      data_q <= in_data;
    end else if (take) begin
      full   <= 1'b0;
    end
  end

  // R5
  hold_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && take) |=> !full);
endmodule

// File: rtl/tx_bit_timer.sv
module tx_bit_timer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_q;

  assign tick = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      div_q <= DIV_W'(1);
    end else if (start) begin
      div_q <= div;
      cnt   <= div - DIV_W'(1);
    end else if (run) begin
      cnt   <= (cnt == '0) ? div_q - DIV_W'(1) : cnt - DIV_W'(1);
    end
  end
endmodule

// File: rtl/tx_frame_shifter.sv
module tx_frame_shifter
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  frame_cfg_t        cfg,
  input  logic              tick,
  output logic              busy,
  output logic              last_end,
  output logic              txd
);
  localparam int FRAME_W = DATA_W + 4;
  localparam int CNT_W   = $clog2(FRAME_W + 1);

  logic [FRAME_W-1:0] frame;
  logic [FRAME_W-1:0] sreg;
  logic [CNT_W-1:0]   nbits;
  logic [CNT_W-1:0]   left;
  logic               par;

  always_comb begin
    par   = cfg.par_odd ? ~(^data) : (^data);
    frame = cfg.par_en ? {2'b11, par, data, 1'b0} : {3'b111, data, 1'b0};
    nbits = CNT_W'(DATA_W + 2) + CNT_W'(cfg.par_en) + CNT_W'(cfg.two_stop);
  end

  assign last_end = tick && (left == CNT_W'(1));
  assign txd      = busy ? sreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sreg <= '1;
      left <= '0;
    end else if (load) begin
      busy <= 1'b1;
      sreg <= frame;
      left <= nbits;
    end else if (tick) begin
      sreg <= {1'b1, sreg[FRAME_W-1:1]};
      left <= left - CNT_W'(1);
      if (left == CNT_W'(1)) busy <= 1'b0;
    end
  end

  // R2
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !tick) |=> $stable(txd));
endmodule

// File: rtl/uart_tx_rs485.sv
module uart_tx_rs485
  import uart_tx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_par_en,
  input  logic              cfg_par_odd,
  input  logic              cfg_two_stop,
  input  logic              tc_ie,
  input  logic              tc_clr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              txd,
  output logic              tc_flag,
  output logic              tc_irq,
  output logic              de
);
  frame_cfg_t        cfg;
  logic              hold_full;
  logic [DATA_W-1:0] hold_data;
  logic              sh_busy;
  logic              last_end;
  logic              tick;
  logic              load;
  logic              accept;
  logic              tc_set;

  assign cfg      = '{par_en: cfg_par_en, par_odd: cfg_par_odd, two_stop: cfg_two_stop};
  assign in_ready = !hold_full;
  assign accept   = in_valid && !hold_full;
  assign load     = hold_full && (!sh_busy || last_end);
  assign tc_set   = last_end && !hold_full && !in_valid;
  assign tc_irq   = tc_flag && tc_ie;

  tx_hold_stage #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .take(load), .full(hold_full), .data_q(hold_data)
  );

  tx_bit_timer #(.DIV_W(DIV_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(load), .run(sh_busy),
    .div(cfg_div), .tick(tick)
  );

  tx_frame_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .data(hold_data), .cfg(cfg),
    .tick(tick), .busy(sh_busy), .last_end(last_end), .txd(txd)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_flag <= 1'b0;
      de      <= 1'b0;
    end else begin
      if (tc_set)                tc_flag <= 1'b1;
      else if (accept || tc_clr) tc_flag <= 1'b0;
      if (accept)                de <= 1'b1;
      else if (tc_set)           de <= 1'b0;
    end
  end

  // R6
  stall_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !sh_busy) |=> in_ready);
  // R7
  tc_line_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_flag) |-> (!sh_busy && in_ready));
  // R9
  de_cover_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> de);
  // R9
  de_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(de) |-> $rose(tc_flag));
endmodule

// File: tb/sim_uart_tx_rs485.sv
module sim_uart_tx_rs485;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_div = 16'd3;
  logic        cfg_par_en = 1'b1, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic        tc_ie = 1'b0, tc_clr = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready, txd, tc_flag, tc_irq, de;

  always #10 clk = ~clk;

  uart_tx_rs485 u0 (
    .clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_par_en(cfg_par_en),
    .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop), .tc_ie(tc_ie),
    .tc_clr(tc_clr), .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .txd(txd), .tc_flag(tc_flag), .tc_irq(tc_irq), .de(de)
  );

  int nchk = 0, nfail = 0;
  int cyc = 0, a0 = 0, fall_cyc = -1;
  bit msg_first = 1'b0, clr_req = 1'b0, de_prev = 1'b0;
  logic [7:0] feed[$];

  // reference model state
  bit m_hfull, m_busy, m_tc, m_de;
  logic [7:0] m_hbyte;
  int m_cnt, m_div;
  bit m_bits[$];
  int m_tags[$];

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      default: return "R2";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hfull = 0; m_busy = 0; m_tc = 0; m_de = 0; m_cnt = 0; m_div = 1;
      m_bits.delete(); m_tags.delete();
    end else begin
      bit acc, endb, last, busy0, tcs;
      cyc++;
      busy0 = m_busy;
      acc   = in_valid && !m_hfull;
      endb  = m_busy && m_cnt == 0;
      last  = endb && m_bits.size() == 1;
      if (m_busy && !endb) m_cnt--;
      else if (endb && !last) begin
        void'(m_bits.pop_front()); void'(m_tags.pop_front()); m_cnt = m_div - 1;
      end else if (last) begin
        m_busy = 0; m_bits.delete(); m_tags.delete();
      end
      tcs = last && !m_hfull && !in_valid;
      if (m_hfull && (!busy0 || last)) begin
        m_bits.delete(); m_tags.delete();
        m_bits.push_back(1'b0); m_tags.push_back(2);
        for (int i = 0; i < 8; i++) begin m_bits.push_back(m_hbyte[i]); m_tags.push_back(2); end
        if (cfg_par_en) begin
          m_bits.push_back(cfg_par_odd ? ~(^m_hbyte) : (^m_hbyte)); m_tags.push_back(3);
        end
        m_bits.push_back(1'b1); m_tags.push_back(4);
        if (cfg_two_stop) begin m_bits.push_back(1'b1); m_tags.push_back(4); end
        m_busy = 1; m_div = int'(cfg_div); m_cnt = m_div - 1; m_hfull = 0;
      end
      if (acc) begin
        m_hfull = 1; m_hbyte = in_data;
        if (msg_first) begin a0 = cyc; msg_first = 0; end
        void'(feed.pop_front());
      end
      if (tcs) m_tc = 1; else if (acc || tc_clr) m_tc = 0;
      if (acc) m_de = 1; else if (tcs) m_de = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(m_busy ? tag_name(m_tags[0]) : "R1", txd, m_busy ? m_bits[0] : 1);
      chk(m_hfull ? "R6" : "R5", in_ready, !m_hfull);
      chk("R7", tc_flag, m_tc);
      chk("R8", tc_irq, m_tc && tc_ie);
      chk("R9", de, m_de);
      if (de_prev && !de) fall_cyc = cyc;
      de_prev = de;
    end
    in_valid = feed.size() > 0;
    in_data  = (feed.size() > 0) ? feed[0] : 8'h00;
    tc_clr   = clr_req;
    clr_req  = 0;
  end

  task automatic set_cfg(input int d, input bit pe, input bit odd, input bit two);
    @(posedge clk); #1;
    cfg_div = 16'(d); cfg_par_en = pe; cfg_par_odd = odd; cfg_two_stop = two;
  endtask

  // pattern: 0 counting, 1 ones/zeros, 2 alternating
  task automatic send_msg(input int n, input int pat, input string req, input bit mid_change);
    int d, nb;
    d  = int'(cfg_div);
    nb = 10 + int'(cfg_par_en) + int'(cfg_two_stop);
    @(posedge clk); #1;
    msg_first = 1; fall_cyc = -1;
    for (int i = 0; i < n; i++)
      feed.push_back(pat == 0 ? 8'(i + 1) : pat == 1 ? ((i % 2) ? 8'h00 : 8'hFF)
                                          : ((i % 2) ? 8'h5A : 8'hA5));
    if (mid_change) begin
      repeat (6) @(posedge clk);
      #1; cfg_div = 16'd1; cfg_par_en = 0; cfg_two_stop = 1;
    end
    do begin @(posedge clk); #1; end while (feed.size() > 0 || m_busy || m_hfull);
    @(negedge clk); #1;
    chk(req, fall_cyc, a0 + 1 + n * nb * d);
    chk("R7", tc_flag, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1; rst_n = 1;
    @(negedge clk); #1;
    chk("R1", txd, 1); chk("R1", in_ready, 1); chk("R1", tc_flag, 0);
    chk("R1", tc_irq, 0); chk("R1", de, 0);
    // even parity, one stop
    set_cfg(3, 1, 0, 0);
    send_msg(1, 0, "R9", 0);
    send_msg(2, 2, "R9", 0);
    send_msg(5, 1, "R9", 0);
    send_msg(10, 0, "R9", 0);
    // odd parity
    set_cfg(2, 1, 1, 0);
    send_msg(5, 2, "R3", 0);
    // no parity, two stop bits
    set_cfg(4, 0, 0, 1);
    send_msg(2, 1, "R4", 0);
    send_msg(10, 2, "R4", 0);
    // one cycle per bit, back-to-back frames
    set_cfg(1, 0, 0, 0);
    send_msg(3, 0, "R5", 0);
    // interrupt and clear
    @(posedge clk); #1; tc_ie = 1;
    @(negedge clk); #1;
    chk("R8", tc_irq, 1);
    @(posedge clk); #1; clr_req = 1;
    repeat (2) @(negedge clk); #1;
    chk("R8", tc_flag, 0); chk("R8", tc_irq, 0);
    tc_ie = 0;
    // configuration changed in mid-frame
    set_cfg(3, 1, 0, 0);
    send_msg(1, 2, "R10", 1);
    set_cfg(2, 1, 1, 0);
    send_msg(2, 0, "R6", 0);
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog R1..all: run did not end, actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule